// File: doc/BRIEF.md
# Quadrature Position Counter with Alternating Reload Values

This block counts position from an incremental encoder. It takes two phase inputs and an index input and keeps a 24-bit count that goes up or down. The phase inputs can be decoded at one, two or four counts per encoder cycle. A plain clock mode is also provided, in which each rising edge of phase A moves the count one step in a direction chosen by software. Every external input passes through a two-flop synchroniser and a stability filter before any edge is detected.

Software reaches the block through a 16-bit word bus with eight addresses. It sets the mode there, and fills two 24-bit reload values. The count can be loaded from a reload value by command, on an index rising edge, or in place of a wrap. The reload value is chosen by a one-bit selector flag, and the flag inverts on every load, so successive loads use the two values in turn.

Reading the low count word captures the whole count into a snapshot, and the high word is later read from that snapshot. A 24-bit value read as two words is therefore consistent even while the count moves. A one-cycle pulse marks every wrap past the top or bottom of the count range.

Top module: `quad_counter`

## Requirements
- R1: After reset the count is 0, the selector flag is 0, the mode word is 0 (plain clock mode, counting disabled, no automatic loads) and the wrap pulse is low.
- R2: Mode code 0 (bits [1:0] of the mode word at address 6) is plain clock mode. Each filtered rising edge of phase A moves the count by one, upward when mode bit 3 is 0 and downward when it is 1. Falling edges do nothing.
- R3: Mode code 1 gives one count per encoder cycle. It counts up on a rising edge of A while B is low and down on a falling edge of A while B is low.
- R4: Mode code 2 counts on both edges of A. The direction is up when A and B differ just after the edge and down when they match.
- R5: Mode code 3 counts on every edge of A and of B. A leading B counts up and B leading A counts down. A cycle in which both filtered phases change together produces no count.
- R6: Phase edges change the count only while mode bit 2 (count enable) is 1. Loads still take effect while it is 0.
- R7: The count wraps modulo 2^24 in both directions. Each wrap raises the wrap pulse output for exactly one clock cycle, on the cycle in which the new count appears.
- R8: Address 2/3 hold the low 16 and upper 8 bits of reload value 0, and address 4/5 hold those of reload value 1. All four words read back. Only bits [7:0] of a high-word write are kept.
- R9: Writing address 7 with bit 0 set loads the count from reload value 0 if the selector flag is 0, or from reload value 1 if it is 1. Every load inverts the flag. Writing address 7 with bit 1 set forces the flag to 0, and this overrides the inversion. The flag reads back at bit 8 of address 6.
- R10: When mode bit 4 is 1, a filtered rising edge of the index input loads the count as in R9. Index edges have no effect when the bit is 0.
- R11: When mode bit 5 is 1, a wrap loads the selected reload value instead of the wrapped count, inverts the flag, and still raises the wrap pulse.
- R12: A read of address 0 returns count bits [15:0] and captures all 24 count bits. Address 1 returns the captured bits [23:16], zero-extended, until the next read of address 0.
- R13: A change on an input that lasts fewer than FILT_LEN (default 3) clock cycles after synchronisation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw phase A input |
| enc_b | input | 1 | Raw phase B input |
| enc_idx | input | 1 | Raw index input |
| bus_wr | input | 1 | Word write strobe, one cycle per access |
| bus_rd | input | 1 | Word read strobe, one cycle per access |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address |
| cnt_value | output | 24 | Live count |
| tc_pulse | output | 1 | One-cycle wrap marker |

## Verification
The assertions assume that a phase edge is meant as a count only when it survives the filter, and that read and write strobes last a single cycle with one access at a time. They also assume that load commands never coincide with a read of address 0. The stimulus holds every raw input level for twelve cycles, well beyond the synchroniser and filter delay, and changes one phase per step. The exceptions are the deliberate simultaneous change of both phases and the glitches that are meant to be rejected. Bus accesses are issued one at a time on falling clock edges.

// File: rtl/qc_pkg.sv
package qc_pkg;
  localparam int ADDR_W  = 3;
  localparam int MODE_W  = 6;
  localparam int TGL_BIT = 8;

  typedef enum logic [1:0] {
    CM_NORMAL = 2'd0,
    CM_X1     = 2'd1,
    CM_X2     = 2'd2,
    CM_X4     = 2'd3
  } clk_mode_e;

  typedef struct packed {
    logic      trig_wrap;
    logic      trig_idx;
    logic      dir_dn;
    logic      cnt_en;
    clk_mode_e cm;
  } mode_t;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_P0_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_P0_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_P1_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_P1_HI  = 3'd5;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd6;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd7;
endpackage

// File: rtl/qc_in_cond.sv
module qc_in_cond #(
  parameter int NUM      = 3,
  parameter int FILT_LEN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] raw_i,
  output logic [NUM-1:0] sync_o,
  output logic [NUM-1:0] filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  for (genvar g = 0; g < NUM; g++) begin : g_ch
    logic [1:0]    sreg;
    logic          flt;
    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sreg <= '0;
        flt  <= 1'b0;
        run  <= '0;
      end else begin
        sreg <= {sreg[0], raw_i[g]};
        if (sreg[1] == flt) begin
          run <= '0;
        end else if (run == CW'(FILT_LEN - 1)) begin
          flt <= sreg[1];
          run <= '0;
        end else begin
          run <= run + CW'(1);
        end
      end
    end

    assign sync_o[g] = sreg[1];
    assign filt_o[g] = flt;
  end
endmodule

// File: rtl/qc_decode.sv
module qc_decode import qc_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      a_i,
  input  logic      b_i,
  input  logic      idx_i,
  input  clk_mode_e cm_i,
  input  logic      dir_dn_i,
  output logic      step_o,
  output logic      up_o,
  output logic      idx_rise_o
);
  logic pa, pb, pidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa   <= 1'b0;
      pb   <= 1'b0;
      pidx <= 1'b0;
    end else begin
      pa   <= a_i;
      pb   <= b_i;
      pidx <= idx_i;
    end
  end

  // returns {step, up} for one phase sample pair
  function automatic logic [1:0] quad_event(clk_mode_e cm, logic dn,
                                            logic qa, logic qb,
                                            logic a, logic b);
    logic da, db;
    logic [1:0] r;
    da = a ^ qa;
    db = b ^ qb;
    r  = 2'b00;
    case (cm)
      CM_NORMAL: r = {a & ~qa, ~dn};
      CM_X1:     r = {da & ~db & ~b, a};
      CM_X2:     r = {da & ~db, a ^ b};
      default:   r = {da ^ db, a ^ qb};
    endcase
    return r;
  endfunction

  always_comb begin
    {step_o, up_o} = quad_event(cm_i, dir_dn_i, pa, pb, a_i, b_i);
    idx_rise_o     = idx_i & ~pidx;
  end
endmodule

// File: rtl/qc_core.sv
module qc_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             en_i,
  input  logic             idx_rise_i,
  input  logic             trig_idx_i,
  input  logic             trig_wrap_i,
  input  logic             sw_load_i,
  input  logic             tgl_clr_i,
  input  logic [CNT_W-1:0] pre0_i,
  input  logic [CNT_W-1:0] pre1_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tgl_o,
  output logic             tc_o,
  output logic             step_ok_o,
  output logic             load_evt_o,
  output logic             wrap_o
);
  logic ext_load;

  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] cur, logic up);
    return up ? cur + CNT_W'(1) : cur - CNT_W'(1);
  endfunction

  function automatic logic at_edge(logic [CNT_W-1:0] cur, logic up);
    return up ? (&cur) : ~(|cur);
  endfunction

  always_comb begin
    ext_load   = sw_load_i | (idx_rise_i & trig_idx_i);
    step_ok_o  = step_i & en_i & ~ext_load;
    wrap_o     = step_ok_o & at_edge(count_o, up_i);
    load_evt_o = ext_load | (wrap_o & trig_wrap_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      tgl_o   <= 1'b0;
      tc_o    <= 1'b0;
    end else begin
      tc_o <= wrap_o;
      if (load_evt_o)
        count_o <= tgl_o ? pre1_i : pre0_i;
      else if (step_ok_o)
        count_o <= next_count(count_o, up_i);
      if (tgl_clr_i)
        tgl_o <= 1'b0;
      else if (load_evt_o)
        tgl_o <= ~tgl_o;
    end
  end
endmodule

// File: rtl/quad_counter.sv
module quad_counter import qc_pkg::*; #(
  parameter int CNT_W    = 24,
  parameter int BUS_W    = 16,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_idx,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [CNT_W-1:0]  cnt_value,
  output logic              tc_pulse
);
  localparam int HI_W = CNT_W - BUS_W;

  // named internal events, observed by the bound checker
  logic [2:0]       sync_v, filt_v;
  logic             step_w, up_w, idx_rise_w;
  logic             step_ok_w, load_evt_w, wrap_w;
  logic             tgl_w, sw_load_w, tgl_clr_w, rd_lo_w;
  mode_t            mode_q;
  logic [CNT_W-1:0] pre0_q, pre1_q, snap_q;

  qc_in_cond #(.NUM(3), .FILT_LEN(FILT_LEN)) u_in (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i ({enc_idx, enc_b, enc_a}),
    .sync_o(sync_v),
    .filt_o(filt_v)
  );

  qc_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_i       (filt_v[0]),
    .b_i       (filt_v[1]),
    .idx_i     (filt_v[2]),
    .cm_i      (mode_q.cm),
    .dir_dn_i  (mode_q.dir_dn),
    .step_o    (step_w),
    .up_o      (up_w),
    .idx_rise_o(idx_rise_w)
  );

  qc_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_w),
    .up_i       (up_w),
    .en_i       (mode_q.cnt_en),
    .idx_rise_i (idx_rise_w),
    .trig_idx_i (mode_q.trig_idx),
    .trig_wrap_i(mode_q.trig_wrap),
    .sw_load_i  (sw_load_w),
    .tgl_clr_i  (tgl_clr_w),
    .pre0_i     (pre0_q),
    .pre1_i     (pre1_q),
    .count_o    (cnt_value),
    .tgl_o      (tgl_w),
    .tc_o       (tc_pulse),
    .step_ok_o  (step_ok_w),
    .load_evt_o (load_evt_w),
    .wrap_o     (wrap_w)
  );

  assign sw_load_w = bus_wr && (bus_addr == A_CMD) && bus_wdata[0];
  assign tgl_clr_w = bus_wr && (bus_addr == A_CMD) && bus_wdata[1];
  assign rd_lo_w   = bus_rd && (bus_addr == A_CNT_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pre0_q <= '0;
      pre1_q <= '0;
      snap_q <= '0;
    end else begin
      if (rd_lo_w)
        snap_q <= cnt_value;
      if (bus_wr) begin
        case (bus_addr)
          A_P0_LO: pre0_q[BUS_W-1:0]     <= bus_wdata;
          A_P0_HI: pre0_q[CNT_W-1:BUS_W] <= bus_wdata[HI_W-1:0];
          A_P1_LO: pre1_q[BUS_W-1:0]     <= bus_wdata;
          A_P1_HI: pre1_q[CNT_W-1:BUS_W] <= bus_wdata[HI_W-1:0];
          A_MODE:  mode_q                <= mode_t'(bus_wdata[MODE_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [BUS_W-1:0] hi_word(logic [CNT_W-1:0] v);
    return BUS_W'(v[CNT_W-1:BUS_W]);
  endfunction

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt_value[BUS_W-1:0];
      A_CNT_HI: bus_rdata = hi_word(snap_q);
      A_P0_LO:  bus_rdata = pre0_q[BUS_W-1:0];
      A_P0_HI:  bus_rdata = hi_word(pre0_q);
      A_P1_LO:  bus_rdata = pre1_q[BUS_W-1:0];
      A_P1_HI:  bus_rdata = hi_word(pre1_q);
      A_MODE: begin
        bus_rdata[MODE_W-1:0] = mode_q;
        bus_rdata[TGL_BIT]    = tgl_w;
      end
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qc_checker.sv
module qc_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] snap,
  input logic             step_ok,
  input logic             load_evt,
  input logic             tgl,
  input logic             tgl_clr,
  input logic             rd_lo,
  input logic             sa,
  input logic             fa,
  input logic             tc
);
  // R6: with no step and no load the count stays put
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !step_ok) |=> $stable(count));

  // R7: an accepted step moves the count by exactly one, modulo the range
  assert_unit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !load_evt) |=>
      ((count - $past(count)) == CNT_W'(1) || (count - $past(count)) == '1));

  // R7, R11: the wrap pulse comes with a range boundary or a reload
  assert_tc_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (count == '0 || count == '1 || $past(load_evt)));

  // R9: each load inverts the selector unless it is cleared in the same cycle
  assert_flag_flips_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !tgl_clr) |=> (tgl != $past(tgl)));

  // R12: the snapshot only moves on a low-word read
  assert_snap_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(snap));

  // R13: the filtered phase only takes a value the synchroniser already held
  assert_filter_source_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (fa != $past(fa)) |-> ($past(sa) == fa));
endmodule

bind quad_counter qc_checker #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .count   (cnt_value),
  .snap    (snap_q),
  .step_ok (step_ok_w),
  .load_evt(load_evt_w),
  .tgl     (tgl_w),
  .tgl_clr (tgl_clr_w),
  .rd_lo   (rd_lo_w),
  .sa      (sync_v[0]),
  .fa      (filt_v[0]),
  .tc      (tc_pulse)
);

// File: tb/quad_counter_tb_top.sv
module quad_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [23:0] cnt_value;
  logic        tc_pulse;

  int checks = 0, failures = 0;
  int tc_seen = 0, tc_long = 0;
  logic tc_prev = 1'b0;
  logic ca = 1'b0, cb = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  quad_counter dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cnt_value(cnt_value), .tc_pulse(tc_pulse)
  );

  always @(negedge clk) begin
    if (tc_pulse) tc_seen++;
    if (tc_pulse && tc_prev) tc_long++;
    tc_prev = tc_pulse;
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic set_ab(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b; ca = a; cb = b;
    settle();
  endtask

  task automatic set_idx(input logic v);
    @(negedge clk);
    enc_idx = v;
    settle();
  endtask

  task automatic quad_fwd(input int n);
    for (int i = 0; i < n; i++) set_ab(~cb, ca);
  endtask

  task automatic quad_rev(input int n);
    for (int i = 0; i < n; i++) set_ab(cb, ~ca);
  endtask

  task automatic load_value(input logic [23:0] v);
    wr(3'd2, v[15:0]);
    wr(3'd3, {8'h00, v[23:16]});
    wr(3'd7, 16'h0002);
    wr(3'd7, 16'h0003);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 count", cnt_value, 24'h0);
    check("R1 tc", {23'h0, tc_pulse}, 24'h0);
    rd(3'd6, d); check("R1 mode/flag", {8'h0, d}, 24'h0);
    rd(3'd1, d); check("R1 high word", {8'h0, d}, 24'h0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(3'd2, 16'h3456); wr(3'd3, 16'hFF12);
    wr(3'd4, 16'hBEEF); wr(3'd5, 16'h00A5);
    rd(3'd2, d); check("R8 pr0 lo", {8'h0, d}, 24'h3456);
    rd(3'd3, d); check("R8 pr0 hi 8 bits kept", {8'h0, d}, 24'h0012);
    rd(3'd4, d); check("R8 pr1 lo", {8'h0, d}, 24'hBEEF);
    rd(3'd5, d); check("R8 pr1 hi", {8'h0, d}, 24'h00A5);
  endtask

  task automatic t_normal();
    set_ab(0, 0);
    load_value(24'h000010);
    wr(3'd6, 16'h0004);
    set_ab(1, 0); check("R2 up on A rise", cnt_value, 24'h000011);
    set_ab(0, 0); check("R2 A fall ignored", cnt_value, 24'h000011);
    wr(3'd6, 16'h000C);
    set_ab(1, 0); check("R2 down on A rise", cnt_value, 24'h000010);
    set_ab(0, 0);
  endtask

  task automatic t_x1();
    set_ab(0, 0);
    load_value(24'h000100);
    wr(3'd6, 16'h0005);
    quad_fwd(4); check("R3 x1 one fwd cycle", cnt_value, 24'h000101);
    quad_fwd(4); check("R3 x1 two fwd cycles", cnt_value, 24'h000102);
    quad_rev(4); check("R3 x1 one rev cycle", cnt_value, 24'h000101);
  endtask

  task automatic t_x2();
    set_ab(0, 0);
    load_value(24'h000100);
    wr(3'd6, 16'h0006);
    quad_fwd(4); check("R4 x2 fwd cycle", cnt_value, 24'h000102);
    quad_rev(2); check("R4 x2 rev half", cnt_value, 24'h000101);
  endtask

  task automatic t_x4();
    set_ab(0, 0);
    load_value(24'h000100);
    wr(3'd6, 16'h0007);
    quad_fwd(3); check("R5 x4 fwd", cnt_value, 24'h000103);
    quad_rev(5); check("R5 x4 rev", cnt_value, 24'h0000FE);
    set_ab(~ca, ~cb); check("R5 both phases change ignored", cnt_value, 24'h0000FE);
  endtask

  task automatic t_enable();
    set_ab(0, 0);
    load_value(24'h000050);
    wr(3'd6, 16'h0003);
    check("R6 load works while disabled", cnt_value, 24'h000050);
    quad_fwd(4); check("R6 disabled holds", cnt_value, 24'h000050);
  endtask

  task automatic t_wrap();
    int t0;
    set_ab(0, 0);
    load_value(24'hFFFFFE);
    wr(3'd6, 16'h0007);
    t0 = tc_seen;
    quad_fwd(1); check("R7 top", cnt_value, 24'hFFFFFF);
    check("R7 no pulse before wrap", tc_seen - t0, 24'd0);
    quad_fwd(1); check("R7 wrap up to zero", cnt_value, 24'h000000);
    check("R7 pulse on up wrap", tc_seen - t0, 24'd1);
    quad_rev(1); check("R7 wrap down", cnt_value, 24'hFFFFFF);
    check("R7 pulse on down wrap", tc_seen - t0, 24'd2);
    check("R7 pulse one cycle", tc_long, 24'd0);
  endtask

  task automatic t_dual();
    logic [15:0] d;
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'h0002);
    wr(3'd2, 16'h3456); wr(3'd3, 16'h0012);
    wr(3'd4, 16'hCDEF); wr(3'd5, 16'h00AB);
    wr(3'd7, 16'h0001); check("R9 first load from pr0", cnt_value, 24'h123456);
    rd(3'd6, d); check("R9 flag set", {23'h0, d[8]}, 24'h1);
    wr(3'd7, 16'h0001); check("R9 second load from pr1", cnt_value, 24'hABCDEF);
    rd(3'd6, d); check("R9 flag back", {23'h0, d[8]}, 24'h0);
    wr(3'd7, 16'h0001); check("R9 third load from pr0", cnt_value, 24'h123456);
    wr(3'd7, 16'h0002);
    rd(3'd6, d); check("R9 flag cleared", {23'h0, d[8]}, 24'h0);
  endtask

  task automatic t_index();
    load_value(24'h000777);
    wr(3'd2, 16'h0AAA); wr(3'd3, 16'h0000);
    wr(3'd4, 16'h0BBB); wr(3'd5, 16'h0000);
    wr(3'd6, 16'h0000);
    set_idx(1); check("R10 index ignored when off", cnt_value, 24'h000777);
    set_idx(0);
    wr(3'd6, 16'h0010);
    set_idx(1); check("R10 index load pr0", cnt_value, 24'h000AAA);
    set_idx(0); check("R10 index fall no load", cnt_value, 24'h000AAA);
    set_idx(1); check("R10 index load pr1", cnt_value, 24'h000BBB);
    set_idx(0);
  endtask

  task automatic t_wrap_reload();
    logic [15:0] d;
    int t0;
    set_ab(0, 0);
    load_value(24'hFFFFFF);
    wr(3'd2, 16'h0200); wr(3'd3, 16'h0000);
    wr(3'd6, 16'h0027);
    t0 = tc_seen;
    quad_fwd(1); check("R11 reload on wrap", cnt_value, 24'h000200);
    check("R11 pulse still raised", tc_seen - t0, 24'd1);
    rd(3'd6, d); check("R11 flag inverted", {23'h0, d[8]}, 24'h1);
    wr(3'd6, 16'h0000);
  endtask

  task automatic t_latch();
    logic [15:0] d;
    load_value(24'h12ABCD);
    rd(3'd0, d); check("R12 low word", {8'h0, d}, 24'h00ABCD);
    load_value(24'h340000);
    rd(3'd1, d); check("R12 high word from snapshot", {8'h0, d}, 24'h000012);
    check("R12 live count moved", cnt_value, 24'h340000);
    rd(3'd0, d); check("R12 new low word", {8'h0, d}, 24'h000000);
    rd(3'd1, d); check("R12 new high word", {8'h0, d}, 24'h000034);
  endtask

  task automatic t_glitch();
    set_ab(0, 0);
    load_value(24'h000100);
    wr(3'd6, 16'h0007);
    @(negedge clk); enc_a = 1'b1;
    @(negedge clk); enc_a = 1'b0;
    settle(); check("R13 one-cycle glitch", cnt_value, 24'h000100);
    @(negedge clk); enc_a = 1'b1;
    repeat (2) @(negedge clk);
    enc_a = 1'b0;
    settle(); check("R13 two-cycle glitch", cnt_value, 24'h000100);
    quad_fwd(1); check("R13 real edge counts", cnt_value, 24'h000101);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_normal();
    t_x1();
    t_x2();
    t_x4();
    t_enable();
    t_wrap();
    t_dual();
    t_index();
    t_wrap_reload();
    t_latch();
    t_glitch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule